// File: doc/BRIEF.md
# SAR ADC Sequencing Controller

This block sequences single conversions of a successive-approximation ADC that has up to eight input channels. A CPU programs it through a small word-addressed register port. One write to the control register picks a channel, turns the converter on and starts a conversion. The controller then counts a programmable settling delay in converter clock periods. It waits a fixed sampling latency, stores the result right-aligned and drops busy. It then flags completion in the control register and, when enabled, on an interrupt line.

The analog converter is modelled as a digital sample bus that carries one value per channel. The controller takes the selected channel's value at the end of the sampling latency. The converter clock is a clock enable that fires once every `CLK_DIV` system cycles. This enable restarts at every accepted start, so the settling delay is exactly `delay * CLK_DIV` system cycles. Any control write with the power bit low turns the converter off and cancels a conversion in progress.

The sequencer has three states. `ST_IDLE` waits for a start. On a start it goes to `ST_PWRUP`, or straight to `ST_SAMPLE` when the delay is zero. `ST_PWRUP` counts converter clocks and moves to `ST_SAMPLE` when the count expires. `ST_SAMPLE` counts `LATENCY` system cycles, then returns to `ST_IDLE` and captures the result in the same edge. Both busy states return to `ST_IDLE` at once on a power-down write.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, the result reads 0, the status word reads 0, the control word reads 0, the delay register reads 8, and `busy` and `irq` are low.
- R2: A control write (word address 2, byte offset 0x08) with bit 3 (power) set while not busy starts a conversion. `busy` and status bit 0 (word 1, offset 0x04) are high from the next cycle.
- R3: After the starting write, `busy` stays high for exactly `D*CLK_DIV + LATENCY` cycles, where D is the 6-bit delay register value. D = 0 skips the power-up phase.
- R4: The result word (word 0, offset 0x00) takes the low `RES` bits of the selected channel's sample (control bits [2:0]), and all higher bits read 0. The result changes in the same edge in which `busy` falls.
- R5: At completion, interrupt status (control bit 6) becomes 1. `irq` is high exactly when interrupt status and interrupt enable (control bit 5) are both 1.
- R6: An accepted control write that has bit 6 low or bit 3 low clears interrupt status. A write with bit 3 low also clears the power output.
- R7: A control write with bit 3 low during a conversion aborts it. `busy` falls in the next cycle, the result is unchanged and no completion is flagged.
- R8: A control write with bit 3 set while busy is ignored. Channel, enable and timing are unchanged, and the result comes from the original channel.
- R9: The delay register (word 3, offset 0x0C) keeps only write data bits [5:0]. Higher bits are ignored and read back as 0.
- R10: The control word reads back as {ist[6], ie[5], 0[4], power[3], channel[2:0]}, with zeros above bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Byte address; bits [3:2] pick the word |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| chan_samples | input | NUM_CH*SAMP_W | Modelled converter output, channel i at bits [i*SAMP_W +: SAMP_W] |
| conv_pwr | output | 1 | Converter power enable (control bit 3) |
| conv_chan | output | 3 | Selected channel |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Completion interrupt |

## Verification
If the sequencer state is wrong, the length of the `busy` pulse is wrong. The bench measures that length to the cycle against `D*CLK_DIV + LATENCY`, so a miscounted delay or latency shows at the completion of the same conversion. If the channel or mask logic is wrong, the result word read back in the cycle after `busy` falls is wrong. If the status flag logic is wrong, `irq` and the control readback show it at once. Aborts and ignored writes are checked by the length of `busy`, the unchanged result and the unchanged control word.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PWRUP  = 2'd1,
        ST_SAMPLE = 2'd2
    } seq_state_e;

    // word indices (byte address bits [3:2])
    localparam logic [1:0] WIX_RESULT = 2'd0;
    localparam logic [1:0] WIX_STATUS = 2'd1;
    localparam logic [1:0] WIX_CTRL   = 2'd2;
    localparam logic [1:0] WIX_DELAY  = 2'd3;

    // control field positions
    localparam int CTL_CH_W    = 3;
    localparam int CTL_PWR_BIT = 3;
    localparam int CTL_IE_BIT  = 5;
    localparam int CTL_IST_BIT = 6;

    localparam int         DLY_W     = 6;
    localparam logic [5:0] DLY_RESET = 6'd8;

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
            logic unused_tick_in;
            assign unused_tick_in = clr;
        end else begin : g_div
            localparam int TW = $clog2(DIV);
            logic [TW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clr || cnt_q == TW'(DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + TW'(1);
                end
            end

            assign tick = (cnt_q == TW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/sar_countdown.sv
module sar_countdown #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int CW      = 6,
    parameter int LATENCY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [DLY_W-1:0] dly,
    input  logic             tick,
    input  logic [CW-1:0]    cnt,
    output logic             cnt_load,
    output logic [CW-1:0]    cnt_val,
    output logic             cnt_dec,
    output logic             tick_clr,
    output logic             busy,
    output logic             capture
);
    seq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (dly == '0) ? ST_SAMPLE : ST_PWRUP;
                end
            end
            ST_PWRUP: begin
                if (abort) begin
                    state_d = ST_IDLE;
                end else if (tick && cnt == CW'(1)) begin
                    state_d = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                if (abort || cnt == CW'(1)) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        tick_clr = 1'b0;
        busy     = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cnt_load = 1'b1;
                    tick_clr = 1'b1;
                    cnt_val  = (dly == '0) ? CW'(LATENCY) : CW'(dly);
                end
            end
            ST_PWRUP: begin
                busy = 1'b1;
                if (!abort) begin
                    if (tick && cnt == CW'(1)) begin
                        cnt_load = 1'b1;
                        cnt_val  = CW'(LATENCY);
                    end else begin
                        cnt_dec = tick;
                    end
                end
            end
            ST_SAMPLE: begin
                busy = 1'b1;
                if (!abort) begin
                    if (cnt == CW'(1)) begin
                        capture = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int SAMP_W  = 16,
    parameter int RES     = 10,
    parameter int CLK_DIV = 2,
    parameter int LATENCY = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               reg_addr,
    input  logic [31:0]              reg_wdata,
    input  logic                     reg_we,
    output logic [31:0]              reg_rdata,
    input  logic [NUM_CH*SAMP_W-1:0] chan_samples,
    output logic                     conv_pwr,
    output logic [CTL_CH_W-1:0]      conv_chan,
    output logic                     busy,
    output logic                     irq
);
    localparam int LAT_W = $clog2(LATENCY + 1);
    localparam int CW    = (LAT_W > DLY_W) ? LAT_W : DLY_W;

    logic [1:0]          widx;
    logic                wr_ctrl, wr_dly, acc_ctrl;
    logic                start, abort, capture, tick, tick_clr;
    logic                cnt_load, cnt_dec;
    logic [CW-1:0]       cnt, cnt_val;

    logic [CTL_CH_W-1:0] ctrl_chan_q;
    logic                ctrl_pwr_q, ctrl_ie_q, ctrl_ist_q;
    logic [DLY_W-1:0]    dly_q;
    logic [RES-1:0]      result_q;
    logic [SAMP_W-1:0]   sel_sample;

    logic unused_bits;
    assign unused_bits = ^{reg_wdata[31:7], reg_wdata[4], reg_addr[1:0], sel_sample};

    assign widx     = reg_addr[3:2];
    assign wr_ctrl  = reg_we && (widx == WIX_CTRL);
    assign wr_dly   = reg_we && (widx == WIX_DELAY);
    assign start    = wr_ctrl && reg_wdata[CTL_PWR_BIT] && !busy;
    assign abort    = wr_ctrl && !reg_wdata[CTL_PWR_BIT];
    assign acc_ctrl = wr_ctrl && (!busy || !reg_wdata[CTL_PWR_BIT]);

    sar_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tick_clr),
        .tick (tick)
    );

    sar_countdown #(.W(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .dec     (cnt_dec),
        .cnt     (cnt)
    );

    sar_seq_fsm #(.CW(CW), .LATENCY(LATENCY)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .abort   (abort),
        .dly     (dly_q),
        .tick    (tick),
        .cnt     (cnt),
        .cnt_load(cnt_load),
        .cnt_val (cnt_val),
        .cnt_dec (cnt_dec),
        .tick_clr(tick_clr),
        .busy    (busy),
        .capture (capture)
    );

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_chan_q <= '0;
            ctrl_pwr_q  <= 1'b0;
            ctrl_ie_q   <= 1'b0;
            ctrl_ist_q  <= 1'b0;
        end else if (acc_ctrl) begin
            ctrl_chan_q <= reg_wdata[CTL_CH_W-1:0];
            ctrl_pwr_q  <= reg_wdata[CTL_PWR_BIT];
            ctrl_ie_q   <= reg_wdata[CTL_IE_BIT];
            ctrl_ist_q  <= ctrl_ist_q && reg_wdata[CTL_IST_BIT] && reg_wdata[CTL_PWR_BIT];
        end else if (capture) begin
            ctrl_ist_q  <= 1'b1;
        end
    end

    // delay register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= DLY_RESET;
        end else if (wr_dly) begin
            dly_q <= reg_wdata[DLY_W-1:0];
        end
    end

    // channel select
    always_comb begin
        sel_sample = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ctrl_chan_q == CTL_CH_W'(i)) begin
                sel_sample = chan_samples[i*SAMP_W +: SAMP_W];
            end
        end
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (capture) begin
            result_q <= sel_sample[RES-1:0];
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (widx)
            WIX_RESULT: reg_rdata[RES-1:0] = result_q;
            WIX_STATUS: reg_rdata[0] = busy;
            WIX_CTRL: begin
                reg_rdata[CTL_CH_W-1:0] = ctrl_chan_q;
                reg_rdata[CTL_PWR_BIT]  = ctrl_pwr_q;
                reg_rdata[CTL_IE_BIT]   = ctrl_ie_q;
                reg_rdata[CTL_IST_BIT]  = ctrl_ist_q;
            end
            WIX_DELAY:  reg_rdata[DLY_W-1:0] = dly_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign conv_pwr  = ctrl_pwr_q;
    assign conv_chan = ctrl_chan_q;
    assign irq       = ctrl_ist_q && ctrl_ie_q;

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [3:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             busy,
    input logic             ist,
    input logic [2:0]       chan,
    input logic [RES_W-1:0] result
);
    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr[3:2] == 2'd2);

    AST_START_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_wr && reg_wdata[3])); // R2

    AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(busy)); // R4

    AST_IST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ist) |-> $fell(busy)); // R5

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !reg_wdata[3]) |=> !ist); // R6

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !reg_wdata[3]) |=> !busy); // R7

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(chan)); // R8
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.RES_W(RES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .busy     (busy),
    .ist      (ctrl_ist_q),
    .chan     (ctrl_chan_q),
    .result   (result_q)
);

// File: tb/sar_seq_ctrl_test.sv
module sar_seq_ctrl_test;
    localparam int NUM_CH  = 8;
    localparam int SAMP_W  = 16;
    localparam int RES     = 10;
    localparam int CLK_DIV = 2;
    localparam int LAT     = 4;
    localparam logic [31:0] MASK = (32'd1 << RES) - 32'd1;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [3:0]               reg_addr = '0;
    logic [31:0]              reg_wdata = '0;
    logic                     reg_we = 1'b0;
    logic [31:0]              reg_rdata;
    logic [NUM_CH*SAMP_W-1:0] chan_samples;
    logic                     conv_pwr, busy, irq;
    logic [2:0]               conv_chan;
    logic [SAMP_W-1:0]        smp [NUM_CH];

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) chan_samples[i*SAMP_W +: SAMP_W] = smp[i];
    end

    sar_seq_ctrl #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W), .RES(RES),
                   .CLK_DIV(CLK_DIV), .LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .chan_samples(chan_samples),
        .conv_pwr(conv_pwr), .conv_chan(conv_chan), .busy(busy), .irq(irq));

    typedef struct {
        int          cycles;
        logic [31:0] value;
        logic        irq;
        string       req;
    } exp_t;

    exp_t        sbq[$];
    int          errors = 0;
    int          checks = 0;
    logic [31:0] last_res = '0;
    bit          finished = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_addr = '0;
    endtask

    task automatic conv_start(input int ch, input bit ie, input int dly, input string req);
        exp_t e;
        wr(4'hC, 32'(dly));
        e.cycles = dly * CLK_DIV + LAT;
        e.value  = 32'(smp[ch]) & MASK;
        e.irq    = ie;
        e.req    = req;
        last_res = e.value;
        sbq.push_back(e);
        wr(4'h8, 32'h8 | (32'(ie) << 5) | 32'(ch));
    endtask

    task automatic wait_done;
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: measures busy length and compares completion against queue
    int run = 0;
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            run = 0;
        end else if (busy) begin
            run++;
        end else if (run > 0) begin
            if (sbq.size() == 0) begin
                chk("R7", "unexpected completion", 32'(run), 32'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (e.cycles >= 0) chk(e.req, "busy length", 32'(run), 32'(e.cycles));
                chk(e.req, "result word", reg_rdata, e.value);
                chk(e.req, "irq at completion", {31'd0, irq}, {31'd0, e.irq});
            end
            run = 0;
        end
    end

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < NUM_CH; i++) smp[i] = 16'(16'hA000 + i * 16'h0111);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R10 reset state
        rd(4'h0, d); chk("R1", "reset result", d, 32'd0);
        rd(4'h4, d); chk("R1", "reset status", d, 32'd0);
        rd(4'h8, d); chk("R1", "reset ctrl", d, 32'd0);
        rd(4'hC, d); chk("R1", "reset delay", d, 32'd8);
        chk("R1", "reset irq/busy", {30'd0, irq, busy}, 32'd0);

        // R9 delay keeps only six bits
        wr(4'hC, 32'hFFFF_FFC5);
        rd(4'hC, d); chk("R9", "delay readback", d, 32'h05);

        // conversion with interrupt: R3 R4 R5
        smp[3] = 16'hF2A5;
        conv_start(3, 1'b1, 8, "R3/R4 ch3 dly8");
        rd(4'h4, d); chk("R2", "status busy", d, 32'd1);
        wait_done();
        rd(4'h8, d); chk("R10", "ctrl after done", d, 32'h6B);
        chk("R5", "irq held", {31'd0, irq}, 32'd1);
        rd(4'h4, d); chk("R2", "status idle", d, 32'd0);

        // R6 power down clears status and irq
        wr(4'h8, 32'h0);
        chk("R6", "irq after power down", {31'd0, irq}, 32'd0);
        chk("R6", "conv_pwr after power down", {31'd0, conv_pwr}, 32'd0);
        rd(4'h8, d); chk("R6", "ctrl after power down", d, 32'd0);

        // R3 zero delay, masking R4, status without irq R5
        smp[0] = 16'hFFFF;
        conv_start(0, 1'b0, 0, "R3 dly0");
        wait_done();
        rd(4'h8, d); chk("R5", "ist set, ie clear", d, 32'h48);
        chk("R5", "irq masked", {31'd0, irq}, 32'd0);

        // R3 maximum delay; start write clears old status (R6)
        smp[7] = 16'h0155;
        conv_start(7, 1'b1, 63, "R3 dly63");
        rd(4'h8, d); chk("R6", "start clears ist", d, 32'h2F);
        chk("R2", "conv_chan", {29'd0, conv_chan}, 32'd7);
        wait_done();

        // R8 ignored write while busy
        smp[1] = 16'h0123; smp[2] = 16'h0321;
        conv_start(1, 1'b1, 8, "R8 ignored write");
        wr(4'h8, 32'h2A);
        rd(4'h8, d); chk("R8", "ctrl unchanged", d, 32'h29);
        wait_done();
        rd(4'h8, d); chk("R8", "ctrl after done", d, 32'h69);

        // R7 abort keeps old result
        begin
            exp_t e;
            logic [31:0] prev;
            prev = last_res;
            wr(4'hC, 32'd8);
            smp[4] = 16'h0077;
            e.cycles = -1; e.value = prev; e.irq = 1'b0; e.req = "R7 abort";
            sbq.push_back(e);
            wr(4'h8, 32'h2C);
            repeat (3) @(negedge clk);
            wr(4'h8, 32'h0);
            chk("R7", "busy after abort", {31'd0, busy}, 32'd0);
            wait_done();
            rd(4'h8, d); chk("R7", "ctrl after abort", d, 32'd0);
            rd(4'h0, d); chk("R7", "result kept", d, prev);
        end

        repeat (4) @(negedge clk);
        chk("R7", "queue drained", 32'(sbq.size()), 32'd0);
        summary();
    end
endmodule